// File: doc/BRIEF.md
# Page Write Cache and Program Sequencer

This block sits on the write side of a serial memory device, behind the protocol engine that decodes the bus. The engine gives it a word address once per transfer. After that it gives one strobe per received data byte. The block keeps each byte in a 64-byte cache of eight lines with eight bytes per line. Each line stands for one aligned 8-byte page of the array. Within a page the byte pointer advances by itself and wraps inside that page.

A transfer can end in two ways. If it closes with a STOP after at least one data byte, the block commits the cache. It walks every cache slot in a fixed order and emits one array write strobe for each byte that was actually written. It then holds a busy flag for a self-timed program period. That period is one page time, counted in tick pulses, for each page loaded. The engine uses the busy flag to withhold acknowledges, and the block ignores all of its inputs while busy is high. If the transfer ends with a repeated START or an abort, the cache is dropped and nothing is written.

Top module: `page_write_cache`

## Requirements
- R1: After reset, busy and memWe are low and the cache holds no data. A STOP right after reset starts no commit.
- R2: An address load sets the byte pointer. Each accepted data byte is stored at the pointer. The pointer's low three bits then increment modulo 8, and the upper bits stay fixed, so a run of bytes wraps inside its page.
- R3: A byte whose page already has a cache line goes into that line. A second byte to the same address replaces the first. A byte to a new page takes a fresh line with all byte valid bits cleared.
- R4: When all eight lines are in use, a byte to a ninth page reuses the line that was allocated earliest. The earlier bytes of that line are lost, and the page count stays at eight.
- R5: A commit emits memWe for exactly the cached bytes that were written, with memAddr = {page, offset} and the stored memData. The slots are visited one per clock, line 0 to 7 and offset 0 to 7 within each line. Slot s is presented in the (s+1)-th cycle after the STOP edge.
- R6: busy rises in the cycle after an accepted STOP. It stays high through the 64 scan cycles and then through pages × PAGE_TICKS tick pulses. It falls in the cycle after the last counted tick.
- R7: While busy is high, address loads, data bytes, STOP and abort strobes have no effect.
- R8: An abort strobe while idle discards the whole cache. A later STOP writes nothing and leaves busy low.
- R9: A STOP with no cached data leaves busy low and emits no writes.
- R10: When a commit completes, the cache is empty. A following STOP with no new data starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadStb | input | 1 | Word address load strobe |
| loadAddr | input | ADDR_W | Word address for the load |
| byteStb | input | 1 | Data byte strobe |
| byteData | input | 8 | Data byte |
| stopStb | input | 1 | Write transfer ended with STOP |
| abortStb | input | 1 | Transfer ended by repeated START or abort |
| tick | input | 1 | Time-base pulse for the program timer |
| memWe | output | 1 | Array byte write strobe |
| memAddr | output | ADDR_W | Array byte address |
| memData | output | 8 | Array write data |
| busy | output | 1 | Program cycle in progress |

## Verification
None of the outputs depends combinationally on an input, so every effect of a strobe first shows after the edge that samples it. busy and the scan start in the cycle after a STOP, slot s appears s+1 cycles after that edge, and busy falls one cycle after the final counted tick. The bench keeps a behavioural model that it advances on the same edge as the design. It compares busy, memWe, memAddr and memData on every falling edge, when inputs are stable and the registered outputs have settled. It also keeps its own copy of the array, updated from memWe, and checks the final contents after each scenario against values worked out from the stimulus.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_HOLD
  } seqStateT;

  // strobes from the sequencer to the cache datapath
  typedef struct packed {
    logic acceptLoad;
    logic acceptByte;
    logic clearAll;
    logic scanStep;
    logic scanActive;
  } ctlStrobesT;

endpackage

// File: rtl/pwc_datapath.sv
module pwc_datapath
  import pwc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int LINES      = 8,
  parameter int LINE_BYTES = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStrobesT                    strobes,
  input  logic [ADDR_W-1:0]             loadAddr,
  input  logic [7:0]                    byteData,
  output logic [$clog2(LINES+1)-1:0]    usedLines,
  output logic                          scanLast,
  output logic                          memWe,
  output logic [ADDR_W-1:0]             memAddr,
  output logic [7:0]                    memData
);

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int LIDX_W = $clog2(LINES);
  localparam int SLOT_W = LIDX_W + OFF_W;
  localparam int SLOTS  = LINES * LINE_BYTES;
  localparam int CNT_W  = $clog2(LINES + 1);

  logic [TAG_W-1:0]  ptrTag;
  logic [OFF_W-1:0]  ptrOff;
  logic [TAG_W-1:0]  lineTag [LINES];
  logic [LINES-1:0]  lineUsed;
  logic [SLOTS-1:0]  byteVal;
  logic [7:0]        byteMem [SLOTS];
  logic [LIDX_W-1:0] victim;
  logic [SLOT_W-1:0] scanIdx;

  // page lookup: one comparator per line
  logic [LINES-1:0] hitVec;
  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign hitVec[g] = lineUsed[g] && (lineTag[g] == ptrTag);
  end

  logic              hit;
  logic [LIDX_W-1:0] hitIdx;
  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (hitVec[i]) begin
        hit    = 1'b1;
        hitIdx = LIDX_W'(i);
      end
    end
  end

  logic [LIDX_W-1:0] wrLine;
  logic [SLOT_W-1:0] wrSlot;
  assign wrLine = hit ? hitIdx : victim;
  assign wrSlot = {wrLine, ptrOff};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrTag    <= '0;
      ptrOff    <= '0;
      lineUsed  <= '0;
      byteVal   <= '0;
      victim    <= '0;
      usedLines <= '0;
      scanIdx   <= '0;
      for (int i = 0; i < LINES; i++) lineTag[i] <= '0;
    end else if (strobes.clearAll) begin
      lineUsed  <= '0;
      byteVal   <= '0;
      victim    <= '0;
      usedLines <= '0;
      scanIdx   <= '0;
    end else begin
      if (strobes.acceptLoad) begin
        ptrTag <= loadAddr[ADDR_W-1:OFF_W];
        ptrOff <= loadAddr[OFF_W-1:0];
      end
      if (strobes.acceptByte) begin
        ptrOff <= ptrOff + 1'b1;
        if (!hit) begin
          lineTag[victim]  <= ptrTag;
          lineUsed[victim] <= 1'b1;
          for (int b = 0; b < LINE_BYTES; b++)
            byteVal[{victim, OFF_W'(b)}] <= 1'b0;
          victim <= (victim == LIDX_W'(LINES - 1)) ? '0 : victim + 1'b1;
          if (usedLines != CNT_W'(LINES)) usedLines <= usedLines + 1'b1;
        end
        byteVal[wrSlot] <= 1'b1;
      end
      if (strobes.scanStep) scanIdx <= scanIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.acceptByte && !strobes.clearAll) byteMem[wrSlot] <= byteData;
  end

  logic [LIDX_W-1:0] scanLine;
  logic [OFF_W-1:0]  scanOff;
  assign scanLine = scanIdx[SLOT_W-1:OFF_W];
  assign scanOff  = scanIdx[OFF_W-1:0];
  assign scanLast = (scanIdx == SLOT_W'(SLOTS - 1));
  assign memWe    = strobes.scanActive && lineUsed[scanLine] && byteVal[scanIdx];
  assign memAddr  = {lineTag[scanLine], scanOff};
  assign memData  = byteMem[scanIdx];

  // R10: a clear leaves no page in the cache
  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll |=> (usedLines == '0));

  // R4: with every line taken, a new byte keeps the page count at the limit
  a_r4_count_saturates: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.acceptByte && !strobes.clearAll && usedLines == CNT_W'(LINES))
      |=> (usedLines == CNT_W'(LINES)));

  // R2: an accepted byte advances the in-page pointer by one
  a_r2_pointer_steps: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.acceptByte && !strobes.acceptLoad && !strobes.clearAll)
      |=> (ptrOff == $past(ptrOff) + 1'b1) && $stable(ptrTag));

endmodule

// File: rtl/pwc_control.sv
module pwc_control
  import pwc_pkg::*;
#(
  parameter int LINES      = 8,
  parameter int PAGE_TICKS = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       loadStb,
  input  logic                       byteStb,
  input  logic                       stopStb,
  input  logic                       abortStb,
  input  logic                       tick,
  input  logic [$clog2(LINES+1)-1:0] usedLines,
  input  logic                       scanLast,
  output ctlStrobesT                 strobes,
  output logic                       busy
);

  localparam int TCNT_W = $clog2(LINES * PAGE_TICKS + 1);

  seqStateT          state;
  logic [TCNT_W-1:0] tickCnt;
  logic [TCNT_W-1:0] target;
  logic              idle;
  logic              holdDone;

  assign idle     = (state == ST_IDLE);
  assign target   = TCNT_W'(usedLines) * TCNT_W'(PAGE_TICKS);
  assign holdDone = (state == ST_HOLD) && tick && (tickCnt + 1'b1 == target);
  assign busy     = !idle;

  always_comb begin
    strobes            = '0;
    strobes.acceptLoad = idle && loadStb && !abortStb && !stopStb;
    strobes.acceptByte = idle && byteStb && !loadStb && !abortStb && !stopStb;
    strobes.clearAll   = (idle && abortStb) || holdDone;
    strobes.scanStep   = (state == ST_SCAN);
    strobes.scanActive = (state == ST_SCAN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (!abortStb && stopStb && usedLines != '0) state <= ST_SCAN;
        ST_SCAN: if (scanLast) begin
          state   <= ST_HOLD;
          tickCnt <= '0;
        end
        ST_HOLD: if (holdDone) state <= ST_IDLE;
                 else if (tick) tickCnt <= tickCnt + 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: a STOP with data starts the busy period on the next cycle
  a_r6_busy_rises: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stopStb && !abortStb && usedLines != '0) |=> busy);

  // R9: a STOP with an empty cache does not start a commit
  a_r9_empty_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stopStb && usedLines == '0) |=> !busy);

  // R7: cache contents are frozen while the program cycle runs
  a_r7_frozen_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!busy || $stable(usedLines)));

endmodule

// File: rtl/page_write_cache.sv
module page_write_cache
  import pwc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int LINES      = 8,
  parameter int LINE_BYTES = 8,
  parameter int PAGE_TICKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStb,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic              byteStb,
  input  logic [7:0]        byteData,
  input  logic              stopStb,
  input  logic              abortStb,
  input  logic              tick,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic              busy
);

  localparam int CNT_W = $clog2(LINES + 1);

  ctlStrobesT       strobes;
  logic [CNT_W-1:0] usedLines;
  logic             scanLast;

  pwc_control #(
    .LINES      (LINES),
    .PAGE_TICKS (PAGE_TICKS)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .loadStb   (loadStb),
    .byteStb   (byteStb),
    .stopStb   (stopStb),
    .abortStb  (abortStb),
    .tick      (tick),
    .usedLines (usedLines),
    .scanLast  (scanLast),
    .strobes   (strobes),
    .busy      (busy)
  );

  pwc_datapath #(
    .ADDR_W     (ADDR_W),
    .LINES      (LINES),
    .LINE_BYTES (LINE_BYTES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .loadAddr  (loadAddr),
    .byteData  (byteData),
    .usedLines (usedLines),
    .scanLast  (scanLast),
    .memWe     (memWe),
    .memAddr   (memAddr),
    .memData   (memData)
  );

  // R5: array writes only happen inside a program cycle
  a_r5_no_write_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memWe);

endmodule

// File: tb/page_write_cache_tb.sv
module page_write_cache_tb;

  localparam int AW = 12;
  localparam int LN = 8;
  localparam int LB = 8;
  localparam int PT = 4;
  localparam int NS = LN * LB;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          loadStb = 1'b0;
  logic [AW-1:0] loadAddr = '0;
  logic          byteStb = 1'b0;
  logic [7:0]    byteData = '0;
  logic          stopStb = 1'b0;
  logic          abortStb = 1'b0;
  logic          tick = 1'b0;
  logic          memWe;
  logic [AW-1:0] memAddr;
  logic [7:0]    memData;
  logic          busy;

  always #2 clk = ~clk;

  page_write_cache #(.ADDR_W(AW), .LINES(LN), .LINE_BYTES(LB), .PAGE_TICKS(PT)) u_dut (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .loadAddr(loadAddr),
    .byteStb(byteStb), .byteData(byteData), .stopStb(stopStb), .abortStb(abortStb),
    .tick(tick), .memWe(memWe), .memAddr(memAddr), .memData(memData), .busy(busy));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] arr [1 << AW];

  // behavioural reference model
  int  mState, mScan, mTicks, mUsed, mVictim, mPtrTag, mPtrOff;
  int  mTag [LN];
  bit  mLineUsed [LN];
  bit  mVal [NS];
  int  mData [NS];

  task automatic modelClear();
    for (int i = 0; i < LN; i++) mLineUsed[i] = 1'b0;
    for (int i = 0; i < NS; i++) mVal[i] = 1'b0;
    mUsed = 0; mVictim = 0; mScan = 0;
  endtask

  task automatic modelByte(input int d);
    int j;
    j = -1;
    for (int i = 0; i < LN; i++) if (mLineUsed[i] && mTag[i] == mPtrTag) j = i;
    if (j < 0) begin
      j = mVictim;
      mTag[j] = mPtrTag;
      mLineUsed[j] = 1'b1;
      for (int b = 0; b < LB; b++) mVal[j*LB+b] = 1'b0;
      mVictim = (mVictim + 1) % LN;
      if (mUsed < LN) mUsed++;
    end
    mData[j*LB+mPtrOff] = d;
    mVal[j*LB+mPtrOff] = 1'b1;
    mPtrOff = (mPtrOff + 1) % LB;
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) arr[i] = 8'h00;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mTicks = 0; mPtrTag = 0; mPtrOff = 0;
      for (int i = 0; i < LN; i++) mTag[i] = 0;
      modelClear();
    end else begin
      if (memWe) arr[memAddr] = memData;
      case (mState)
        0: begin
          if (abortStb) modelClear();
          else if (stopStb) begin
            if (mUsed > 0) begin mState = 1; mScan = 0; end
          end else if (loadStb) begin
            mPtrTag = int'(loadAddr) / LB; mPtrOff = int'(loadAddr) % LB;
          end else if (byteStb) modelByte(int'(byteData));
        end
        1: begin
          if (mScan == NS - 1) begin mState = 2; mTicks = 0; mScan = 0; end
          else mScan++;
        end
        default: begin
          if (tick) begin
            mTicks++;
            if (mTicks == mUsed * PT) begin mState = 0; modelClear(); end
          end
        end
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    bit expWe;
    int expAddr, expData;
    cyc++;
    if (rstN) begin
      expWe   = (mState == 1) && mVal[mScan];
      expAddr = mTag[mScan / LB] * LB + (mScan % LB);
      expData = mData[mScan];
      checks++;
      if (busy !== (mState != 0)) begin
        errors++;
        $display("FAIL R6 busy cycle %0d: actual %0b expected %0b", cyc, busy, mState != 0);
      end
      checks++;
      if (memWe !== expWe || (expWe && (int'(memAddr) != expAddr || int'(memData) != expData))) begin
        errors++;
        $display("FAIL R5 write cycle %0d: actual we=%0b a=%h d=%h expected we=%0b a=%h d=%h",
                 cyc, memWe, memAddr, memData, expWe, expAddr, expData);
      end
    end
  end

  // time base: one tick every third cycle
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 3;
    tick <= (tdiv == 0);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(input int kind, input int val);
    @(negedge clk);
    case (kind)
      0: begin loadStb = 1'b1; loadAddr = AW'(val); end
      1: begin byteStb = 1'b1; byteData = 8'(val); end
      2: stopStb = 1'b1;
      default: abortStb = 1'b1;
    endcase
    @(negedge clk);
    loadStb = 1'b0; byteStb = 1'b0; stopStb = 1'b0; abortStb = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 memWe after reset", int'(memWe), 0);
    pulse(2, 0);
    repeat (2) @(negedge clk);
    chk("R1 stop after reset", int'(busy), 0);

    // R2: in-page wrap
    pulse(0, 'h123);
    for (int i = 0; i < 7; i++) pulse(1, 'hA0 + i);
    pulse(2, 0);
    waitIdle();
    chk("R2 addr 123", int'(arr['h123]), 'hA0);
    chk("R2 addr 127", int'(arr['h127]), 'hA4);
    chk("R2 wrap 120", int'(arr['h120]), 'hA5);
    chk("R2 wrap 121", int'(arr['h121]), 'hA6);
    chk("R5 untouched 122", int'(arr['h122]), 0);

    // R3: multi page, hit and overwrite
    pulse(0, 'h010); pulse(1, 'hB0); pulse(1, 'hB1);
    pulse(0, 'h200); pulse(1, 'hB2);
    pulse(0, 'h012); pulse(1, 'hB3);
    pulse(0, 'h010); pulse(1, 'hB4);
    pulse(2, 0);
    waitIdle();
    chk("R3 overwrite 010", int'(arr['h010]), 'hB4);
    chk("R3 addr 011", int'(arr['h011]), 'hB1);
    chk("R3 hit 012", int'(arr['h012]), 'hB3);
    chk("R3 page 200", int'(arr['h200]), 'hB2);

    // R4: ninth page reuses oldest line
    for (int i = 0; i < 9; i++) begin pulse(0, 'h400 + i * LB); pulse(1, 'hC0 + i); end
    pulse(2, 0);
    waitIdle();
    chk("R4 oldest dropped 400", int'(arr['h400]), 0);
    chk("R4 page 408", int'(arr['h408]), 'hC1);
    chk("R4 ninth page 440", int'(arr['h440]), 'hC8);

    // R8: abort discards
    pulse(0, 'h600); pulse(1, 'h55); pulse(3, 0); pulse(2, 0);
    repeat (3) @(negedge clk);
    chk("R8 busy after abort+stop", int'(busy), 0);
    waitIdle();
    chk("R8 addr 600", int'(arr['h600]), 0);

    // R9: empty stop
    pulse(2, 0);
    repeat (3) @(negedge clk);
    chk("R9 busy on empty stop", int'(busy), 0);

    // R7 and R10: inputs ignored while busy, cache empty afterwards
    pulse(0, 'h700); pulse(1, 'h11); pulse(2, 0);
    repeat (70) @(negedge clk);
    chk("R7 busy in hold", int'(busy), 1);
    pulse(0, 'h708); pulse(1, 'h22); pulse(2, 0); pulse(3, 0);
    waitIdle();
    chk("R7 addr 700", int'(arr['h700]), 'h11);
    chk("R7 ignored byte 708", int'(arr['h708]), 0);
    pulse(2, 0);
    repeat (3) @(negedge clk);
    chk("R10 stop after commit", int'(busy), 0);
    waitIdle();
    chk("R10 addr 708 still clear", int'(arr['h708]), 0);

    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule